// File: doc/BRIEF.md
# Outstanding Read Miss Tracker

This block sits beside a non-blocking data cache and keeps a record of every cache line that has missed and is still being fetched. Independent work can continue while the line is on its way. The cache presents each load miss with its line address, the word offset within the line, and a destination tag. The tracker either opens a new entry for the line and sends one request to memory, or adds the load to the entry that already waits on that line. The second case sends nothing to memory.

Memory answers each request with a whole line, quoting the entry index that came with the request. The tracker keeps that line in the entry. It then returns the waiting loads one per cycle, each with the word its offset selects, and frees the entry after the last one. When the tracker has no room, it holds off further misses with a ready signal. That happens when every entry is busy with other lines, or when the entry for the line has used all its load slots.

Top module: `miss_tracker`

## Requirements
- R1: After reset, `miss_ready` is high and `mreq_valid` and `resp_valid` are low.
- R2: An accepted miss whose line matches no live entry takes the lowest-numbered free entry. One cycle later the block pulses `mreq_valid` for one cycle, with `mreq_line` set to the miss line and `mreq_id` set to that entry's index.
- R3: An accepted miss whose line matches a live entry joins that entry and produces no memory request.
- R4: Responses start in the cycle after the fill is accepted and come one per cycle, in the order the loads were accepted. Each response carries the load's tag. Its data is word `off` of the filled line, where word k occupies bits k*WORD_W and up of `fill_data`.
- R5: An entry is freed once its last response has been given. A later miss to the same line then opens a new entry and issues a new request.
- R6: When every entry is live and none matches the miss line, `miss_ready` is low and the miss is not taken.
- R7: When the matching entry has already accepted SLOTS loads since it was opened, `miss_ready` is low for that line.
- R8: A miss to a line presented in the same cycle as that line's fill is accepted as a join. It is answered from that fill, after the loads already waiting.
- R9: When several filled entries hold waiting loads, the lowest-numbered entry is answered first in each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A load miss is presented |
| miss_ready | output | 1 | The presented miss is taken this cycle |
| miss_line | input | LINE_AW | Line address of the miss |
| miss_off | input | OFF_W | Word offset within the line |
| miss_tag | input | TAG_W | Destination tag of the load |
| mreq_valid | output | 1 | One-cycle memory read request |
| mreq_line | output | LINE_AW | Line address to fetch |
| mreq_id | output | $clog2(N) | Entry index the fill must quote |
| fill_valid | input | 1 | Line data is returned |
| fill_id | input | $clog2(N) | Entry index of the returned line |
| fill_data | input | WORD_W<<OFF_W | Whole line, word k at bits k*WORD_W |
| resp_valid | output | 1 | A load response is given |
| resp_tag | output | TAG_W | Tag of the answered load |
| resp_data | output | WORD_W | Word selected by the load's offset |

## Verification
The assertions check a set of rules on every cycle: a join never issues a request, a new-line acceptance always issues one, a refused miss issues none, every request names a live entry, and responses never begin without a fill in the cycle before. Several things show only in the bench's scenarios: which entry is chosen, the order and data of each response, when entries are freed, the same-cycle join with a fill, and lowest-index priority among draining entries. The bench sweeps every mix of live-entry count and loads-per-entry, and also runs dedicated cases for the same-cycle fill and the drain priority.

// File: rtl/miss_tracker.sv
module miss_tracker #(
  parameter int N       = 4,
  parameter int SLOTS   = 4,
  parameter int LINE_AW = 16,
  parameter int OFF_W   = 2,
  parameter int WORD_W  = 16,
  parameter int TAG_W   = 6,
  localparam int IDX_W  = $clog2(N),
  localparam int CNT_W  = $clog2(SLOTS + 1),
  localparam int LINE_W = WORD_W << OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_valid,
  output logic               miss_ready,
  input  logic [LINE_AW-1:0] miss_line,
  input  logic [OFF_W-1:0]   miss_off,
  input  logic [TAG_W-1:0]   miss_tag,
  output logic               mreq_valid,
  output logic [LINE_AW-1:0] mreq_line,
  output logic [IDX_W-1:0]   mreq_id,
  input  logic               fill_valid,
  input  logic [IDX_W-1:0]   fill_id,
  input  logic [LINE_W-1:0]  fill_data,
  output logic               resp_valid,
  output logic [TAG_W-1:0]   resp_tag,
  output logic [WORD_W-1:0]  resp_data
);

  logic [N-1:0]       vld_q, fil_q;
  logic [LINE_AW-1:0] line_q [N];
  logic [LINE_W-1:0]  data_q [N];
  logic [CNT_W-1:0]   push_q [N];
  logic [CNT_W-1:0]   pop_q  [N];
  logic [TAG_W-1:0]   tag_q  [N][SLOTS];
  logic [OFF_W-1:0]   off_q  [N][SLOTS];

  logic [CNT_W-1:0]   push_d [N];
  logic [CNT_W-1:0]   pop_d  [N];
  logic [N-1:0]       free_d;

  logic               any_hit, any_free, any_drn;
  logic [IDX_W-1:0]   hit_idx, free_idx, drn_idx, wr_idx;
  logic [CNT_W-1:0]   wslot;
  logic [TAG_W-1:0]   rtag;
  logic [OFF_W-1:0]   roff;
  logic               take, merge, alloc;

  always_comb begin
    any_hit = 1'b0; any_free = 1'b0; any_drn = 1'b0;
    hit_idx = '0; free_idx = '0; drn_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vld_q[i] && line_q[i] == miss_line) begin any_hit = 1'b1; hit_idx = IDX_W'(i); end
      if (!vld_q[i]) begin any_free = 1'b1; free_idx = IDX_W'(i); end
      if (vld_q[i] && fil_q[i]) begin any_drn = 1'b1; drn_idx = IDX_W'(i); end
    end
  end

  assign miss_ready = any_hit ? (push_q[hit_idx] != CNT_W'(SLOTS)) : any_free;
  assign take   = miss_valid && miss_ready;
  assign merge  = take && any_hit;
  assign alloc  = take && !any_hit;
  assign wr_idx = any_hit ? hit_idx : free_idx;
  assign wslot  = any_hit ? push_q[hit_idx] : '0;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (alloc && free_idx == IDX_W'(i)) begin
        push_d[i] = CNT_W'(1);
        pop_d[i]  = '0;
      end else begin
        push_d[i] = push_q[i] + CNT_W'(merge && hit_idx == IDX_W'(i));
        pop_d[i]  = pop_q[i] + CNT_W'(any_drn && drn_idx == IDX_W'(i));
      end
      free_d[i] = fil_q[i] && (pop_d[i] == push_d[i]);
    end
  end

  always_comb begin
    rtag = '0; roff = '0;
    for (int s = 0; s < SLOTS; s++)
      if (CNT_W'(s) == pop_q[drn_idx]) begin
        rtag = tag_q[drn_idx][s];
        roff = off_q[drn_idx][s];
      end
  end

  assign resp_valid = any_drn;
  assign resp_tag   = rtag;
  assign resp_data  = data_q[drn_idx][roff*WORD_W +: WORD_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      fil_q <= '0;
      mreq_valid <= 1'b0;
      mreq_line  <= '0;
      mreq_id    <= '0;
      for (int i = 0; i < N; i++) begin
        push_q[i] <= '0;
        pop_q[i]  <= '0;
      end
    end else begin
      mreq_valid <= alloc;
      if (alloc) begin
        mreq_line <= miss_line;
        mreq_id   <= free_idx;
      end
      for (int i = 0; i < N; i++) begin
        push_q[i] <= push_d[i];
        pop_q[i]  <= pop_d[i];
        if (alloc && free_idx == IDX_W'(i)) begin
          vld_q[i]  <= 1'b1;
          fil_q[i]  <= 1'b0;
          line_q[i] <= miss_line;
        end else if (free_d[i]) begin
          vld_q[i] <= 1'b0;
          fil_q[i] <= 1'b0;
        end else if (fill_valid && fill_id == IDX_W'(i)) begin
          fil_q[i]  <= 1'b1;
          data_q[i] <= fill_data;
        end
        for (int s = 0; s < SLOTS; s++)
          if (take && wr_idx == IDX_W'(i) && wslot == CNT_W'(s)) begin
            tag_q[i][s] <= miss_tag;
            off_q[i][s] <= miss_off;
          end
      end
    end
  end

endmodule

// File: rtl/miss_tracker_chk.sv
module miss_tracker_chk #(
  parameter int N = 4,
  localparam int IDX_W = $clog2(N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             miss_valid,
  input logic             miss_ready,
  input logic             any_hit,
  input logic             mreq_valid,
  input logic [IDX_W-1:0] mreq_id,
  input logic [N-1:0]     vld_q,
  input logic             fill_valid,
  input logic             resp_valid
);

  a_r3_join_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && miss_ready && any_hit |=> !mreq_valid);

  a_r2_new_line_requests: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && miss_ready && !any_hit |=> mreq_valid);

  a_r6_refused_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && !miss_ready |=> !mreq_valid);

  a_r2_request_names_live: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> vld_q[mreq_id]);

  a_r4_drain_follows_fill: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_valid) |-> $past(fill_valid));

endmodule

bind miss_tracker miss_tracker_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
  .any_hit(any_hit), .mreq_valid(mreq_valid), .mreq_id(mreq_id), .vld_q(vld_q),
  .fill_valid(fill_valid), .resp_valid(resp_valid)
);

// File: tb/sim_miss_tracker.sv
`timescale 1ns/1ps
module sim_miss_tracker;
  localparam int N = 4, SLOTS = 4, LINE_AW = 16, OFF_W = 2, WORD_W = 16, TAG_W = 6;
  localparam int IDX_W = $clog2(N);
  localparam int LINE_W = WORD_W << OFF_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic miss_valid = 1'b0, fill_valid = 1'b0;
  logic [LINE_AW-1:0] miss_line = '0;
  logic [OFF_W-1:0] miss_off = '0;
  logic [TAG_W-1:0] miss_tag = '0;
  logic [IDX_W-1:0] fill_id = '0;
  logic [LINE_W-1:0] fill_data = '0;
  logic miss_ready, mreq_valid, resp_valid;
  logic [LINE_AW-1:0] mreq_line;
  logic [IDX_W-1:0] mreq_id;
  logic [TAG_W-1:0] resp_tag;
  logic [WORD_W-1:0] resp_data;

  miss_tracker u0 (.*);

  always #10 clk = ~clk;

  int cyc = 0, tests = 0, fails = 0;
  int qcnt = 0, rcnt = 0;
  logic [LINE_AW-1:0] qline [64];
  logic [IDX_W-1:0] qid [64];
  logic [TAG_W-1:0] rtag [64];
  logic [WORD_W-1:0] rdat [64];
  int rst_at [64];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (mreq_valid && qcnt < 64) begin qline[qcnt] = mreq_line; qid[qcnt] = mreq_id; qcnt++; end
    if (resp_valid && rcnt < 64) begin rtag[rcnt] = resp_tag; rdat[rcnt] = resp_data; rst_at[rcnt] = cyc; rcnt++; end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  function automatic logic [WORD_W-1:0] wrd(input logic [LINE_AW-1:0] ln, input int j);
    return WORD_W'(int'(ln) * 5 + j * 17 + 3);
  endfunction

  function automatic logic [LINE_W-1:0] line_of(input logic [LINE_AW-1:0] ln);
    logic [LINE_W-1:0] d;
    for (int j = 0; j < (1 << OFF_W); j++) d[j*WORD_W +: WORD_W] = wrd(ln, j);
    return d;
  endfunction

  task automatic miss(input logic [LINE_AW-1:0] ln, input int off, input int tg, output bit acc);
    @(negedge clk);
    miss_valid = 1'b1; miss_line = ln; miss_off = OFF_W'(off); miss_tag = TAG_W'(tg);
    #1 acc = miss_ready;
    @(posedge clk); #1 miss_valid = 1'b0;
  endtask

  task automatic fill(input int id, input logic [LINE_AW-1:0] ln, output int st);
    @(negedge clk);
    fill_valid = 1'b1; fill_id = IDX_W'(id); fill_data = line_of(ln); st = cyc;
    @(posedge clk); #1 fill_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit acc;
    int fs, fs2, tg;
    logic [LINE_AW-1:0] ln [N];
    int etag [N][SLOTS];
    int eoff [N][SLOTS];
    tg = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk(miss_ready == 1'b1, "R1 ready", miss_ready, 1);
    chk(mreq_valid == 1'b0, "R1 mreq", mreq_valid, 0);
    chk(resp_valid == 1'b0, "R1 resp", resp_valid, 0);

    for (int n = 1; n <= N; n++) begin
      for (int k = 1; k <= SLOTS; k++) begin
        for (int e = 0; e < N; e++) ln[e] = LINE_AW'(16'h100 + n * 64 + k * 8 + e);
        qcnt = 0;
        for (int s = 0; s < k; s++)
          for (int e = 0; e < n; e++) begin
            etag[e][s] = tg % 64; eoff[e][s] = (s + e) % 4;
            miss(ln[e], eoff[e][s], etag[e][s], acc);
            tg++;
            chk(acc == 1'b1, s == 0 ? "R2 accept new line" : "R3 accept join", acc, 1);
          end
        idle(2);
        chk(qcnt == n, "R3 one request per line", qcnt, n);
        for (int e = 0; e < n; e++) begin
          chk(qline[e] == ln[e], "R2 request line", qline[e], ln[e]);
          chk(qid[e] == IDX_W'(e), "R2 lowest free entry", qid[e], e);
        end
        if (n == N) begin
          miss(16'hBEEF, 0, 63, acc);
          chk(acc == 1'b0, "R6 full table refuses", acc, 0);
          if (k < SLOTS) begin
            miss(ln[0], 2, tg % 64, acc);
            chk(acc == 1'b1, "R6 join still taken", acc, 1);
            etag[0][k] = tg % 64; eoff[0][k] = 2; tg++;
          end
        end
        if (k == SLOTS) begin
          miss(ln[0], 1, 62, acc);
          chk(acc == 1'b0, "R7 slots full refuses", acc, 0);
        end
        idle(1);
        chk(qcnt == n, "R3 no request from join or refusal", qcnt, n);
        for (int e = n - 1; e >= 0; e--) begin
          int cnt;
          cnt = (n == N && k < SLOTS && e == 0) ? k + 1 : k;
          rcnt = 0;
          fill(e, ln[e], fs);
          idle(cnt + 2);
          chk(rcnt == cnt, "R4 response count", rcnt, cnt);
          for (int j = 0; j < cnt && j < rcnt; j++) begin
            chk(rtag[j] == TAG_W'(etag[e][j]), "R4 order tag", rtag[j], etag[e][j]);
            chk(rdat[j] == wrd(ln[e], eoff[e][j]), "R4 word data", rdat[j], wrd(ln[e], eoff[e][j]));
            chk(rst_at[j] == fs + 1 + j, "R4 one per cycle", rst_at[j], fs + 1 + j);
          end
        end
        qcnt = 0;
        miss(ln[0], 3, 7, acc);
        idle(2);
        chk(acc == 1'b1 && qcnt == 1, "R5 freed line requests again", qcnt, 1);
        chk(qid[0] == '0, "R5 reuses entry 0", qid[0], 0);
        rcnt = 0;
        fill(0, ln[0], fs);
        idle(3);
        chk(rcnt == 1 && rdat[0] == wrd(ln[0], 3), "R5 reopened entry answered", rdat[0], wrd(ln[0], 3));
      end
    end

    qcnt = 0; rcnt = 0;
    miss(16'h0777, 1, 50, acc);
    idle(2);
    @(negedge clk);
    fill_valid = 1'b1; fill_id = '0; fill_data = line_of(16'h0777); fs = cyc;
    miss_valid = 1'b1; miss_line = 16'h0777; miss_off = 2'd3; miss_tag = 6'd51;
    #1 acc = miss_ready;
    @(posedge clk); #1 fill_valid = 1'b0; miss_valid = 1'b0;
    idle(4);
    chk(acc == 1'b1, "R8 join with fill taken", acc, 1);
    chk(qcnt == 1, "R8 no extra request", qcnt, 1);
    chk(rcnt == 2, "R8 both answered", rcnt, 2);
    chk(rtag[1] == 6'd51 && rst_at[1] == fs + 2, "R8 joined load answered second", rtag[1], 51);
    chk(rdat[1] == wrd(16'h0777, 3), "R8 data from same fill", rdat[1], wrd(16'h0777, 3));

    qcnt = 0; rcnt = 0;
    miss(16'h0A00, 0, 60, acc);
    miss(16'h0A01, 1, 61, acc);
    miss(16'h0A01, 2, 62, acc);
    idle(2);
    fill(1, 16'h0A01, fs);
    fill(0, 16'h0A00, fs2);
    idle(5);
    chk(rcnt == 3, "R9 response count", rcnt, 3);
    chk(rtag[0] == 6'd61 && rst_at[0] == fs + 1, "R9 first from entry 1", rtag[0], 61);
    chk(rtag[1] == 6'd60 && rst_at[1] == fs + 2, "R9 entry 0 takes priority", rtag[1], 60);
    chk(rtag[2] == 6'd62 && rst_at[2] == fs + 3, "R9 entry 1 resumes", rtag[2], 62);
    chk(fs2 == fs + 1, "R9 fills back to back", fs2, fs + 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule